// File: doc/BRIEF.md
# Sine Test-Tone Burst Generator

This block generates a repeating audio test pattern: bursts of a 1 kHz sine tone separated by silent gaps. A 20-point sine table is stepped at a fixed sample rate derived from the system clock by an internal divider. Each table value is packed into a 16-bit converter command word. The word is presented on a parallel output together with a one-cycle valid strobe. Shifting the word out to the converter is left to a separate serialiser.

A burst consists of a fixed number of complete passes through the table. After the last sample of a burst the output goes quiet for a programmable number of clock cycles. The table then restarts at its first entry and the next burst begins, indefinitely. The divider, the burst length and the gap are parameters counted in clock cycles. With the defaults (5000 clocks per sample at 100 MHz, 250 passes, a 25,000,000-clock gap) the block produces 20,000 samples per second, 250 ms bursts and 250 ms gaps. A simulation can shrink all three. `TICK_DIV` must be at least 2.

Top module: `tone_burst_gen`

## Requirements
- R1: Within each table pass the emitted samples follow the order 127, 166, 202, 230, 248, 254, 248, 230, 202, 166, 127, 88, 52, 24, 6, 0, 6, 24, 52, 88 (table index 0 to 19).
- R2: During a burst, consecutive strobes are exactly `TICK_DIV` clock cycles apart, and each strobe lasts one cycle.
- R3: A burst holds exactly `CYCLES_PER_BURST` complete table passes, and each pass, including the first pass of every burst, starts again at table index 0.
- R4: Every strobed word has bits [15:12] = 4'b0011, bits [11:4] = the 8-bit sample and bits [3:0] = 4'b0000.
- R5: The first strobe of a burst comes `GAP_CLKS + TICK_DIV` cycles after the last strobe of the previous burst. No strobe occurs in between, and the word output keeps its last value whenever the strobe is low.
- R6: While `enable` is low, no strobe is produced and the table index and pass count are cleared. The first strobe after `enable` rises comes `TICK_DIV` cycles later with table entry 0, and it begins a complete burst.
- R7: While `rst_n` is low at a clock edge, the word output is cleared to 0 and the strobe is low.
- R8: Bursts and gaps keep alternating for as long as `enable` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the generator; low returns it to idle |
| dac_word | output | 16 | Converter command word: config nibble, sample, zero nibble |
| dac_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
The properties assume that `enable` and `rst_n` are changed only away from the rising clock edge and are at a defined level from time zero. They also assume `TICK_DIV` is at least 2, so that a single-cycle strobe can be told apart from a stuck one. The bench drives both control inputs on the falling edge and holds reset low from the start. It uses a divider of 4, three passes per burst and a 50-cycle gap, so that every edge of the burst/gap cycle is reached quickly. Enable is dropped partway through a burst and reset is applied while the generator is running, so that the clearing rules are exercised outside the idle state as well.

// File: rtl/tbg_pkg.sv
// Package tbg_pkg: shared types and helpers for the tone burst generator.
// Holds the sine table as a function and the converter word formatter.
package tbg_pkg;
    localparam int SAMPLES = 20;
    localparam int IDX_W   = 5;
    localparam int WORD_W  = 16;
    localparam logic [3:0] CFG_NIBBLE = 4'b0011;

    typedef enum logic [1:0] {PH_IDLE, PH_BURST, PH_GAP} phase_t;

    // One period of the tone, 20 points, mid-scale 127.
    function automatic logic [7:0] sine_point(input logic [IDX_W-1:0] i);
        case (i)
            5'd0:  return 8'd127;
            5'd1:  return 8'd166;
            5'd2:  return 8'd202;
            5'd3:  return 8'd230;
            5'd4:  return 8'd248;
            5'd5:  return 8'd254;
            5'd6:  return 8'd248;
            5'd7:  return 8'd230;
            5'd8:  return 8'd202;
            5'd9:  return 8'd166;
            5'd10: return 8'd127;
            5'd11: return 8'd88;
            5'd12: return 8'd52;
            5'd13: return 8'd24;
            5'd14: return 8'd6;
            5'd15: return 8'd0;
            5'd16: return 8'd6;
            5'd17: return 8'd24;
            5'd18: return 8'd52;
            5'd19: return 8'd88;
            default: return 8'd127;
        endcase
    endfunction

    // Place a sample in the middle of a converter command word.
    function automatic logic [WORD_W-1:0] fmt_dac_word(input logic [7:0] s);
        return {CFG_NIBBLE, s, 4'b0000};
    endfunction
endpackage

// File: rtl/tbg_tick_div.sv
// tbg_tick_div: sample-rate divider. While run is high it pulses tick
// once every TICK_DIV clocks; when run is low the count is held at zero.
// Assumes TICK_DIV >= 2.
module tbg_tick_div #(
    parameter int TICK_DIV = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks while running, wrapping at the divider limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/tbg_sine_rom.sv
// tbg_sine_rom: combinational lookup of one table point.
// Assumes idx stays below SAMPLES; other values read mid-scale.
module tbg_sine_rom
    import tbg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       sample
);
    // Table lookup.
    always_comb sample = sine_point(idx);
endmodule

// File: rtl/tbg_burst_seq.sv
// tbg_burst_seq: walks the table index, counts table passes and times
// the silent gap. fire marks a tick that must emit a sample.
// Assumes tick comes from a divider that is stopped during the gap.
module tbg_burst_seq
    import tbg_pkg::*;
#(
    parameter int CYCLES_PER_BURST = 250,
    parameter int GAP_CLKS         = 25_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    output phase_t           phase,
    output logic [IDX_W-1:0] idx,
    output logic             fire
);
    localparam int CYC_W = (CYCLES_PER_BURST > 1) ? $clog2(CYCLES_PER_BURST) : 1;
    localparam int GAP_W = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLES - 1);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(CYCLES_PER_BURST - 1);
    localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_CLKS - 1);

    logic [CYC_W-1:0] cyc;
    logic [GAP_W-1:0] gap;

    assign fire = tick && (phase == PH_BURST);

    // Phase, index, pass and gap bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= PH_IDLE;
            idx   <= '0;
            cyc   <= '0;
            gap   <= '0;
        end else begin
            case (phase)
                PH_IDLE: phase <= PH_BURST;
                PH_BURST: begin
                    if (tick) begin
                        if (idx == LAST_IDX) begin
                            idx <= '0;
                            if (cyc == LAST_CYC) begin
                                cyc   <= '0;
                                gap   <= '0;
                                phase <= PH_GAP;
                            end else begin
                                cyc <= cyc + 1'b1;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_GAP: begin
                    if (gap == LAST_GAP)
                        phase <= PH_BURST;
                    else
                        gap <= gap + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tone_burst_gen.sv
// tone_burst_gen: top of the test-tone burst generator. Divider, sequencer
// and table feed a registered word/strobe output.
// Assumes TICK_DIV >= 2 and CYCLES_PER_BURST, GAP_CLKS >= 1.
module tone_burst_gen
    import tbg_pkg::*;
#(
    parameter int TICK_DIV         = 5000,
    parameter int CYCLES_PER_BURST = 250,
    parameter int GAP_CLKS         = 25_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    output logic [15:0] dac_word,
    output logic        dac_valid
);
    phase_t           phase;
    logic [IDX_W-1:0] idx;
    logic             tick;
    logic             fire;
    logic             run;
    logic [7:0]       sample;

    assign run = enable && (phase != PH_GAP);

    tbg_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    tbg_burst_seq #(
        .CYCLES_PER_BURST (CYCLES_PER_BURST),
        .GAP_CLKS         (GAP_CLKS)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .tick   (tick),
        .phase  (phase),
        .idx    (idx),
        .fire   (fire)
    );

    tbg_sine_rom u_rom (
        .idx    (idx),
        .sample (sample)
    );

    // Output register: load a formatted word and strobe on each fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word  <= '0;
            dac_valid <= 1'b0;
        end else begin
            dac_valid <= fire;
            if (fire)
                dac_word <= fmt_dac_word(sample);
        end
    end
endmodule

// File: rtl/tbg_checker.sv
// tbg_checker: protocol properties of tone_burst_gen, bound to the top.
// Assumes control inputs are defined from time zero.
module tbg_checker
    import tbg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [15:0]      dac_word,
    input logic             dac_valid,
    input phase_t           phase,
    input logic [IDX_W-1:0] idx
);
    p_strobe_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    p_gap_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase) == PH_GAP) |-> !dac_valid);

    p_word_format_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> (dac_word[15:12] == 4'b0011 && dac_word[3:0] == 4'b0000));

    p_word_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !dac_valid) |-> $stable(dac_word));

    p_idle_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enable)) |-> (idx == '0 && phase == PH_IDLE && !dac_valid));
endmodule

bind tone_burst_gen tbg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .dac_word  (dac_word),
    .dac_valid (dac_valid),
    .phase     (phase),
    .idx       (idx)
);

// File: tb/tb_tone_burst_gen.sv
module tb_tone_burst_gen;
    localparam int TICK = 4;
    localparam int CYC  = 3;
    localparam int GAP  = 50;
    localparam int NSMP = 20;
    localparam int LIMIT = 1000;

    // Stimulus/expectation vectors: the sample expected at each table index.
    localparam logic [7:0] SINE_TBL [NSMP] = '{
        8'd127, 8'd166, 8'd202, 8'd230, 8'd248, 8'd254, 8'd248, 8'd230, 8'd202, 8'd166,
        8'd127, 8'd88,  8'd52,  8'd24,  8'd6,   8'd0,   8'd6,   8'd24,  8'd52,  8'd88};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] dac_word;
    logic        dac_valid;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tone_burst_gen #(.TICK_DIV(TICK), .CYCLES_PER_BURST(CYC), .GAP_CLKS(GAP)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .dac_word  (dac_word),
        .dac_valid (dac_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Wait from a falling edge for the next strobe; n = cycles waited.
    task automatic wait_valid(output int n, output bit held);
        logic [15:0] w0;
        w0 = dac_word;
        n = 0;
        held = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (!dac_valid && dac_word !== w0) held = 1'b0;
        end while (!dac_valid && n < LIMIT);
    endtask

    // Check one strobed sample against table index s and spacing exp_n.
    task automatic check_sample(input int s, input int exp_n, input string req_gap);
        int  n;
        bit  held;
        wait_valid(n, held);
        check(n == exp_n, req_gap, "strobe spacing", n, exp_n);
        check(dac_word[11:4] == SINE_TBL[s], "R1", "sample value", dac_word[11:4], SINE_TBL[s]);
        check(dac_word[15:12] == 4'b0011 && dac_word[3:0] == 4'b0000, "R4",
              "word nibbles", dac_word, {4'b0011, SINE_TBL[s], 4'b0000});
        if (exp_n != TICK)
            check(held, "R5", "word held in gap", held, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int  bad;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(dac_word == 16'h0 && !dac_valid, "R7", "reset outputs", dac_word, 0);
        rst_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (dac_valid) bad++;
        end
        check(bad == 0, "R6", "no strobe while disabled", bad, 0);

        // Burst 1: walk the vector table CYC times (R1, R2, R3, R4).
        enable = 1'b1;
        for (int p = 0; p < CYC; p++)
            for (int s = 0; s < NSMP; s++)
                check_sample(s, TICK, "R2");

        // Burst 2 begins after the gap at index 0 (R3, R5), runs full length.
        check_sample(0, GAP + TICK, "R5");
        for (int k = 1; k < CYC * NSMP; k++)
            check_sample(k % NSMP, TICK, "R3");

        // Burst 3 repeats (R8); drop enable after 7 samples.
        check_sample(0, GAP + TICK, "R8");
        for (int k = 1; k < 7; k++)
            check_sample(k, TICK, "R2");
        enable = 1'b0;
        begin
            logic [15:0] w0;
            w0 = dac_word;
            bad = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (dac_valid || dac_word !== w0) bad++;
            end
            check(bad == 0, "R6", "silent and held while disabled", bad, 0);
        end

        // Re-enable: restarts at index 0 with a full burst (R6).
        enable = 1'b1;
        check_sample(0, TICK, "R6");
        for (int k = 1; k < CYC * NSMP; k++)
            check_sample(k % NSMP, TICK, "R6");
        check_sample(0, GAP + TICK, "R6");

        // Reset while running (R7).
        check_sample(1, TICK, "R2");
        rst_n = 1'b0;
        @(negedge clk);
        check(dac_word == 16'h0 && !dac_valid, "R7", "reset while running", dac_word, 0);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (dac_valid) bad++;
        end
        check(bad == 0, "R7", "no strobe in reset", bad, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule